// File: doc/BRIEF.md
# Per-Pin Two-Bit Edge Sense Interrupt Unit

This unit watches 32 input pins and turns selected transitions into latched events. Each pin owns a two-bit sense code that chooses rising edges, falling edges, both edges, or nothing. The codes for the lower sixteen pins live in one configuration register and those for the upper sixteen in a second one. Captured events sit in a register that software clears by writing ones. A mask register selects which events drive the single combined interrupt line.

The pins pass through a two-stage synchronizer before edge detection, so asynchronous inputs can be wired straight in. A direction register is also provided. Its bits for the four highest-numbered pins are fixed at input, so a driver cannot turn those pins into outputs.

All 32-bit registers number pins from the top: pin n is bit 31 − n. The pin input and direction output vectors follow the same rule. Register offsets (byte addresses on a 5-bit bus, reads combinational): direction 0x00, event 0x0C, mask 0x10, low sense 0x14, high sense 0x18.

Top module: `pin_event_unit`

## Requirements
- R1: Pin p in 0–15 reads its sense code from the register at 0x14, and pin p in 16–31 from the one at 0x18. Within either register the code sits at bits [s+1:s] with s = 2·(15 − (p mod 16)), and the registers read back as written.
- R2: Sense code 00 records an event on a rising transition and also on a falling transition of the pin.
- R3: Sense code 01 records an event on a rising transition only.
- R4: Sense code 10 records an event on a falling transition only.
- R5: Sense code 11 never records an event for that pin.
- R6: Event bit 31 − n is set by an event on pin n and stays set until a bus write to 0x0C carries a 1 in that bit. Zero bits in such a write leave their events unchanged.
- R7: The interrupt output is high exactly when some bit is set in both the event register and the mask register (0x10, read back as written).
- R8: Direction register bits for pins 28–31 (bits 3:0) always read 0 and ignore writes. All other bits are writable. The direction output equals the register.
- R9: After reset the direction, mask, both sense registers and the event register read 0, and the interrupt output is low.
- R10: When a clearing write to 0x0C and a new event on the same pin fall in the same clock cycle, the event stays set. Other bits in the same write are still cleared.
- R11: Rewriting a sense register does not change events that are already pending.
- R12: An event on a pin input change is visible in the event register after the third rising clock edge following the change, and not after the second.
- R13: Reads from any offset other than the five listed return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Write strobe for the register bus |
| reg_addr | input | 5 | Byte offset of the accessed register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| pin_in | input | 32 | Asynchronous pin levels, pin n on bit 31 − n |
| pin_dir | output | 32 | Direction per pin, 1 = output, pin n on bit 31 − n |
| irq | output | 1 | Combined interrupt request |

## Verification
The risky overlap is a write-one-to-clear on the event register landing on the same edge that a new transition on that pin is being captured. The bench sets up two pending events, then toggles one of those pins. It times the clearing write so that it lands on the third edge after the toggle, which is the edge on which that pin's new capture is latched. The write covers both pins. The check passes when the toggled pin's bit survives and the other pin's bit is gone. A second overlap, a sense-register rewrite while events are pending, is judged by reading the event register right after the write.

// File: rtl/pev_pkg.sv
package pev_pkg;
  localparam int PIN_COUNT  = 32;
  localparam int DATA_W     = 32;
  localparam int ADDR_W     = 5;
  localparam int GROUP_SIZE = 16;
  localparam int FIRST_INPUT_ONLY = 28;

  localparam logic [ADDR_W-1:0] OFS_DIR   = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_EVT   = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_MASK  = 5'h10;
  localparam logic [ADDR_W-1:0] OFS_SNS_A = 5'h14;
  localparam logic [ADDR_W-1:0] OFS_SNS_B = 5'h18;

  typedef enum logic [1:0] {
    SENSE_ANY  = 2'b00,
    SENSE_RISE = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_OFF  = 2'b11
  } sense_e;

  // vector index carrying pin p (top-first numbering)
  function automatic int pin_bit(input int p);
    return DATA_W - 1 - p;
  endfunction

  // low bit of the two-bit sense field of pin p
  function automatic int field_lsb(input int p);
    return 2 * (GROUP_SIZE - 1 - (p % GROUP_SIZE));
  endfunction

  // direction bits that may be set to output
  function automatic logic [DATA_W-1:0] dir_writable();
    logic [DATA_W-1:0] m;
    m = '1;
    for (int p = FIRST_INPUT_ONLY; p < PIN_COUNT; p++) m[pin_bit(p)] = 1'b0;
    return m;
  endfunction

  function automatic sense_e field_of(input logic [DATA_W-1:0] sns_a,
                                      input logic [DATA_W-1:0] sns_b,
                                      input int p);
    logic [DATA_W-1:0] r;
    r = (p >= GROUP_SIZE) ? sns_b : sns_a;
    return sense_e'(r[field_lsb(p) +: 2]);
  endfunction
endpackage

// File: rtl/pev_sync.sv
module pev_sync #(
  parameter int W = pev_pkg::PIN_COUNT
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] cur_q,
  output logic [W-1:0] prev_q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= '0;
      cur_q  <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= async_in;
      cur_q  <= meta_q;
      prev_q <= cur_q;
    end
  end
endmodule

// File: rtl/pev_edge_detect.sv
module pev_edge_detect
  import pev_pkg::*;
(
  input  logic [DATA_W-1:0] cur,
  input  logic [DATA_W-1:0] prev,
  input  logic [DATA_W-1:0] sns_a,
  input  logic [DATA_W-1:0] sns_b,
  output logic [DATA_W-1:0] hit
);
  for (genvar p = 0; p < PIN_COUNT; p++) begin : g_pin
    localparam int B = pin_bit(p);
    sense_e code;
    logic   rise, fall;

    assign code = field_of(sns_a, sns_b, p);
    assign rise = cur[B] & ~prev[B];
    assign fall = ~cur[B] & prev[B];

    always_comb begin
      unique case (code)
        SENSE_ANY:  hit[B] = rise | fall;
        SENSE_RISE: hit[B] = rise;
        SENSE_FALL: hit[B] = fall;
        default:    hit[B] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/pev_regs.sv
module pev_regs
  import pev_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] hit,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] dir_q,
  output logic [DATA_W-1:0] mask_q,
  output logic [DATA_W-1:0] sns_a_q,
  output logic [DATA_W-1:0] sns_b_q,
  output logic [DATA_W-1:0] evt_q
);
  localparam logic [DATA_W-1:0] DIR_WMASK = dir_writable();

  logic wr_dir, wr_evt, wr_mask, wr_a, wr_b;
  logic [DATA_W-1:0] clr_bits;

  assign wr_dir  = wr_en && (addr == OFS_DIR);
  assign wr_evt  = wr_en && (addr == OFS_EVT);
  assign wr_mask = wr_en && (addr == OFS_MASK);
  assign wr_a    = wr_en && (addr == OFS_SNS_A);
  assign wr_b    = wr_en && (addr == OFS_SNS_B);
  assign clr_bits = wr_evt ? wdata : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q   <= '0;
      mask_q  <= '0;
      sns_a_q <= '0;
      sns_b_q <= '0;
      evt_q   <= '0;
    end else begin
      if (wr_dir)  dir_q   <= wdata & DIR_WMASK;
      if (wr_mask) mask_q  <= wdata;
      if (wr_a)    sns_a_q <= wdata;
      if (wr_b)    sns_b_q <= wdata;
      // a fresh capture outranks a clear of the same bit
      evt_q <= (evt_q & ~clr_bits) | hit;
    end
  end

  always_comb begin
    unique case (addr)
      OFS_DIR:   rdata = dir_q;
      OFS_EVT:   rdata = evt_q;
      OFS_MASK:  rdata = mask_q;
      OFS_SNS_A: rdata = sns_a_q;
      OFS_SNS_B: rdata = sns_b_q;
      default:   rdata = '0;
    endcase
  end

  // R6
  evt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_evt |=> ((evt_q & $past(evt_q)) == $past(evt_q)));

  // R10
  capture_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_evt && (|hit)) |=> ((evt_q & $past(hit)) == $past(hit)));
endmodule

// File: rtl/pin_event_unit.sv
module pin_event_unit
  import pev_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [4:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [31:0]       pin_in,
  output logic [31:0]       pin_dir,
  output logic              irq
);
  logic [DATA_W-1:0] s_now, s_prev, hit;
  logic [DATA_W-1:0] dir_q, mask_q, sns_a_q, sns_b_q, evt_q;

  pev_sync #(.W(DATA_W)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (pin_in),
    .cur_q    (s_now),
    .prev_q   (s_prev)
  );

  pev_edge_detect u_edge (
    .cur   (s_now),
    .prev  (s_prev),
    .sns_a (sns_a_q),
    .sns_b (sns_b_q),
    .hit   (hit)
  );

  pev_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (reg_wr_en),
    .addr    (reg_addr),
    .wdata   (reg_wdata),
    .hit     (hit),
    .rdata   (reg_rdata),
    .dir_q   (dir_q),
    .mask_q  (mask_q),
    .sns_a_q (sns_a_q),
    .sns_b_q (sns_b_q),
    .evt_q   (evt_q)
  );

  assign pin_dir = dir_q;
  assign irq     = |(evt_q & mask_q);

  for (genvar p = 0; p < PIN_COUNT; p++) begin : g_chk
    localparam int B = pin_bit(p);
    logic [1:0] code_v;
    assign code_v = field_of(sns_a_q, sns_b_q, p);

    // R5
    off_code_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(evt_q[B]) |-> ($past(code_v) != 2'b11));

    // R12
    synced_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(evt_q[B]) |-> $past(s_now[B] != s_prev[B]));
  end
endmodule

// File: tb/pin_event_unit_bench.sv
`timescale 1ns/100ps
module pin_event_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_dir;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  localparam logic [4:0] A_DIR = 5'h00, A_EVT = 5'h0C, A_MSK = 5'h10,
                         A_LO = 5'h14, A_HI = 5'h18;

  always #2.5 clk = ~clk;

  pin_event_unit u_pin_event_unit (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
    .pin_dir(pin_dir), .irq(irq)
  );

  function automatic logic [31:0] bm(input int n);
    return 32'h8000_0000 >> n;
  endfunction

  // field of pin n inside its group register, computed from the requirement
  function automatic logic [31:0] fld(input int n, input logic [1:0] c);
    return {30'd0, c} << (30 - 2 * (n & 15));
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #0.5 d = reg_rdata;
  endtask

  task automatic pin(input int n, input logic v);
    @(negedge clk);
    pin_in[31-n] = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic clear_all();
    wr(A_EVT, 32'hFFFF_FFFF);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(A_DIR, d); chk("R9 dir", d, 0);
    rd(A_EVT, d); chk("R9 evt", d, 0);
    rd(A_MSK, d); chk("R9 mask", d, 0);
    rd(A_LO, d);  chk("R9 sense lo", d, 0);
    rd(A_HI, d);  chk("R9 sense hi", d, 0);
    chk("R9 irq", {31'd0, irq}, 0);
    chk("R9 pin_dir", pin_dir, 0);
  endtask

  task automatic t_both_edges();
    logic [31:0] d;
    pin(5, 1'b1);
    rd(A_EVT, d); chk("R2 rise on code 00", d, bm(5));
    wr(A_EVT, 32'h0);
    rd(A_EVT, d); chk("R6 zero write keeps", d, bm(5));
    wr(A_EVT, bm(5));
    rd(A_EVT, d); chk("R6 one clears", d, 0);
    pin(5, 1'b0);
    rd(A_EVT, d); chk("R2 fall on code 00", d, bm(5));
    clear_all();
  endtask

  task automatic t_latency();
    @(negedge clk);
    pin_in[31-6] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    reg_addr = A_EVT;
    #0.5 chk("R12 not after 2nd edge", reg_rdata, 0);
    @(negedge clk);
    #0.5 chk("R12 set after 3rd edge", reg_rdata, bm(6));
    pin(6, 1'b0);
    clear_all();
  endtask

  task automatic t_rising();
    logic [31:0] d;
    wr(A_LO, fld(3, 2'b01));
    wr(A_HI, fld(20, 2'b01));
    rd(A_LO, d); chk("R1 lo readback", d, 32'h0100_0000);
    rd(A_HI, d); chk("R1 hi readback", d, 32'h0040_0000);
    pin(3, 1'b1);
    rd(A_EVT, d); chk("R3 rise pin3", d, bm(3));
    clear_all();
    pin(3, 1'b0);
    rd(A_EVT, d); chk("R3 fall ignored pin3", d, 0);
    pin(20, 1'b1);
    rd(A_EVT, d); chk("R1 R3 rise pin20 via hi reg", d, bm(20));
    clear_all();
    pin(20, 1'b0);
    rd(A_EVT, d); chk("R3 fall ignored pin20", d, 0);
    wr(A_LO, 0); wr(A_HI, 0);
  endtask

  task automatic t_falling();
    logic [31:0] d;
    wr(A_LO, fld(12, 2'b10));
    wr(A_HI, fld(30, 2'b10));
    pin(12, 1'b1); pin(30, 1'b1);
    rd(A_EVT, d); chk("R4 rises ignored", d, 0);
    pin(12, 1'b0); pin(30, 1'b0);
    rd(A_EVT, d); chk("R4 falls captured", d, bm(12) | bm(30));
    clear_all();
    wr(A_LO, 0); wr(A_HI, 0);
  endtask

  task automatic t_reserved();
    logic [31:0] d;
    wr(A_LO, fld(10, 2'b11));
    @(negedge clk);
    pin_in[31-10] = 1'b1; pin_in[31-9] = 1'b1;
    repeat (4) @(negedge clk);
    rd(A_EVT, d); chk("R5 R1 code 11 only on pin10", d, bm(9));
    clear_all();
    @(negedge clk);
    pin_in[31-10] = 1'b0; pin_in[31-9] = 1'b0;
    repeat (4) @(negedge clk);
    rd(A_EVT, d); chk("R5 falling also silent", d, bm(9));
    clear_all();
    wr(A_LO, 0);
  endtask

  task automatic t_irq();
    logic [31:0] d;
    wr(A_MSK, bm(4));
    rd(A_MSK, d); chk("R7 mask readback", d, bm(4));
    pin(5, 1'b1);
    chk("R7 unmasked event no irq", {31'd0, irq}, 0);
    pin(4, 1'b1);
    chk("R7 masked-in event irq", {31'd0, irq}, 1);
    wr(A_EVT, bm(4));
    @(negedge clk);
    chk("R7 irq drops after clear", {31'd0, irq}, 0);
    wr(A_MSK, 0);
    pin(4, 1'b0); pin(5, 1'b0);
    clear_all();
  endtask

  task automatic t_dir();
    logic [31:0] d;
    wr(A_DIR, 32'hFFFF_FFFF);
    rd(A_DIR, d); chk("R8 input-only bits stay 0", d, 32'hFFFF_FFF0);
    chk("R8 pin_dir follows", pin_dir, 32'hFFFF_FFF0);
    wr(A_DIR, 32'h0000_000F);
    rd(A_DIR, d); chk("R8 writes to pins 28-31 ignored", d, 0);
    wr(A_DIR, 32'h0000_0000);
  endtask

  task automatic t_collision();
    logic [31:0] d;
    pin(7, 1'b1); pin(8, 1'b1);
    rd(A_EVT, d); chk("R10 setup pending", d, bm(7) | bm(8));
    @(negedge clk);
    pin_in[31-7] = 1'b0;
    @(negedge clk);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = A_EVT; reg_wdata = bm(7) | bm(8);
    @(negedge clk);
    reg_wr_en = 1'b0;
    rd(A_EVT, d); chk("R10 capture wins, other cleared", d, bm(7));
    pin(8, 1'b0);
    clear_all();
  endtask

  task automatic t_reconfig();
    logic [31:0] d;
    pin(2, 1'b1);
    wr(A_LO, fld(2, 2'b11));
    rd(A_EVT, d); chk("R11 pending kept over rewrite", d, bm(2));
    clear_all();
    pin(2, 1'b0);
    rd(A_EVT, d); chk("R11 new code in force", d, 0);
    wr(A_LO, 0);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    wr(A_MSK, 32'hA5A5_A5A5);
    rd(5'h04, d); chk("R13 offset 04", d, 0);
    rd(5'h08, d); chk("R13 offset 08", d, 0);
    rd(5'h1C, d); chk("R13 offset 1C", d, 0);
    wr(A_MSK, 0);
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_both_edges();
    t_latency();
    t_rising();
    t_falling();
    t_reserved();
    t_irq();
    t_dir();
    t_collision();
    t_reconfig();
    t_unmapped();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule